// File: doc/BRIEF.md
# Hinge Router Turn Selection Unit

This block sits in each router of a reply-plane mesh whose paths are time-multiplexed circuits. A reply flit crosses every router of its row in one cycle over straight-through bypass wires. Every router it passes also copies it into a per-input holding latch. In the following cycle each router looks at its own latched copies, independently of the others, and decides what to do with each one. It turns the flit north or south onto the column bypass, ejects it to the local port, or discards it. There is no route computation and no arbitration. The crossbar configuration of the current time window names which crossbar inputs take their source from a latch. Only those latches are examined.

Each latch slot is a two-state machine. `SLOT_EMPTY` moves to `SLOT_HELD` on LOAD, when an incoming flit is written. `SLOT_HELD` stays in `SLOT_HELD` on REPLACE, when a new flit is written in the same cycle as the old one leaves. It also stays in `SLOT_HELD` on HOLD, when the slot is not examined or no flit leaves. `SLOT_HELD` returns to `SLOT_EMPTY` on RELEASE, when the held flit is forwarded or discarded and no new flit arrives. The decision is purely combinational on the latch contents, the router coordinates and the configuration. The column hop is taken in the next cycle, so a whole path takes at most three cycles.

Top module: `hinge_turn_select`

## Requirements
- R1: After reset every slot is in `SLOT_EMPTY`. No output valid is raised and no drop strobe is raised.
- R2: A flit presented with its slot's arrival valid is captured at the next clock edge and is acted on from the following cycle.
- R3: A held flit in a slot whose configuration bit is 0 raises no select and no drop. It stays held and is acted on once that bit becomes 1.
- R4: The destination X sits in header bits [XW-1:0]. When it differs from the router X, the slot's drop strobe is raised, no output is driven, and the slot is empty afterwards.
- R5: The destination Y sits in header bits [XW+YW-1:XW]. When X matches and destination Y is greater than the router Y, the flit goes to the north output.
- R6: When X matches and destination Y is less than the router Y, the flit goes to the south output.
- R7: When both X and Y match, the flit goes to the local output.
- R8: A slot that forwards or drops its flit is cleared at the same clock edge, so the flit appears for exactly one cycle.
- R9: A flit arriving in the cycle a slot forwards or drops takes priority over the clear, and that new flit is held.
- R10: Each output carries all W bits of the selected flit unchanged.
- R11: At most one slot drives any one output in a cycle. Forwarding and dropping are exclusive per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | XW | Router X coordinate |
| my_y | input | YW | Router Y coordinate |
| cfg_latch_src | input | N | Per slot: 1 when the current configuration takes this input from its latch |
| in_valid | input | N | Per slot: a flit arrives this cycle |
| in_flit | input | N*W | Arriving flits, slot i at bits [i*W +: W] |
| north_valid | output | 1 | North output carries a flit |
| north_flit | output | W | North output data |
| south_valid | output | 1 | South output carries a flit |
| south_flit | output | W | South output data |
| local_valid | output | 1 | Local output carries a flit |
| local_flit | output | W | Local output data |
| north_sel | output | N | Mux select, one bit per slot, for north |
| south_sel | output | N | Mux select, one bit per slot, for south |
| local_sel | output | N | Mux select, one bit per slot, for local |
| drop | output | N | Per-slot discard strobe |

## Verification
The turn decision is tried with destinations above, below and equal to the router row, and with a foreign column. This separates the north, south, local and drop branches, and a swapped comparison shows up as a flit on the wrong port. Two slots are resolved in one cycle to different outputs, which exposes cross-talk in the muxes. A slot is left unconfigured for several cycles and then enabled, which separates holding from clearing. Arrivals are placed in the very cycle a slot is forwarding, and in the very cycle it is dropping, which tells whether the write wins over the clear.

// File: rtl/hr_pkg.sv
package hr_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    typedef enum logic [2:0] {
        DIR_NONE  = 3'd0,
        DIR_NORTH = 3'd1,
        DIR_SOUTH = 3'd2,
        DIR_LOCAL = 3'd3,
        DIR_DROP  = 3'd4
    } turn_dir_e;
endpackage

// File: rtl/hr_latch_slot.sv
module hr_latch_slot
    import hr_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_flit,
    input  logic         release_i,
    output logic         held,
    output logic [W-1:0] flit
);
    slot_state_e state_q, state_d;
    logic [W-1:0] data_q;

    // next-state: an arriving flit always wins over the clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: state_d = load ? SLOT_HELD : SLOT_EMPTY;
            SLOT_HELD: begin
                if (load)           state_d = SLOT_HELD;
                else if (release_i) state_d = SLOT_EMPTY;
                else                state_d = SLOT_HELD;
            end
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) data_q <= load_flit;
        end
    end

    always_comb begin
        held = (state_q == SLOT_HELD);
        flit = data_q;
    end
endmodule

// File: rtl/hr_turn_decide.sv
module hr_turn_decide
    import hr_pkg::*;
#(
    parameter int W  = 64,
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic          examine,
    input  logic [W-1:0]  flit,
    input  logic [XW-1:0] my_x,
    input  logic [YW-1:0] my_y,
    output turn_dir_e     dir
);
    logic [XW-1:0] dest_x;
    logic [YW-1:0] dest_y;

    always_comb begin
        dest_x = flit[XW-1:0];
        dest_y = flit[XW+YW-1:XW];
        dir    = DIR_NONE;
        if (examine) begin
            if (dest_x != my_x)      dir = DIR_DROP;
            else if (dest_y > my_y)  dir = DIR_NORTH;
            else if (dest_y < my_y)  dir = DIR_SOUTH;
            else                     dir = DIR_LOCAL;
        end
    end
endmodule

// File: rtl/hr_out_mux.sv
module hr_out_mux #(
    parameter int N = 3,
    parameter int W = 64
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] flits,
    output logic           out_valid,
    output logic [W-1:0]   out_flit
);
    always_comb begin
        out_valid = |sel;
        out_flit  = '0;
        for (int i = 0; i < N; i++) begin
            out_flit = out_flit | (flits[i*W +: W] & {W{sel[i]}});
        end
    end
endmodule

// File: rtl/hinge_turn_select.sv
module hinge_turn_select
    import hr_pkg::*;
#(
    parameter int N  = 3,
    parameter int W  = 64,
    parameter int XW = 2,
    parameter int YW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [XW-1:0]  my_x,
    input  logic [YW-1:0]  my_y,
    input  logic [N-1:0]   cfg_latch_src,
    input  logic [N-1:0]   in_valid,
    input  logic [N*W-1:0] in_flit,
    output logic           north_valid,
    output logic [W-1:0]   north_flit,
    output logic           south_valid,
    output logic [W-1:0]   south_flit,
    output logic           local_valid,
    output logic [W-1:0]   local_flit,
    output logic [N-1:0]   north_sel,
    output logic [N-1:0]   south_sel,
    output logic [N-1:0]   local_sel,
    output logic [N-1:0]   drop
);
    localparam int HDR_W = XW + YW;

    logic [N-1:0]   slot_held;
    logic [N-1:0]   slot_release;
    logic [N*W-1:0] slot_flit;

    generate
        if (HDR_W > W) begin : g_bad_hdr
            initial $error("header wider than flit");
        end
        for (genvar i = 0; i < N; i++) begin : g_slot
            turn_dir_e dir;

            hr_latch_slot #(.W(W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (in_valid[i]),
                .load_flit (in_flit[i*W +: W]),
                .release_i (slot_release[i]),
                .held      (slot_held[i]),
                .flit      (slot_flit[i*W +: W])
            );

            hr_turn_decide #(.W(W), .XW(XW), .YW(YW)) u_dec (
                .examine (cfg_latch_src[i] & slot_held[i]),
                .flit    (slot_flit[i*W +: W]),
                .my_x    (my_x),
                .my_y    (my_y),
                .dir     (dir)
            );

            always_comb begin
                north_sel[i]    = (dir == DIR_NORTH);
                south_sel[i]    = (dir == DIR_SOUTH);
                local_sel[i]    = (dir == DIR_LOCAL);
                drop[i]         = (dir == DIR_DROP);
                slot_release[i] = (dir != DIR_NONE);
            end
        end
    endgenerate

    hr_out_mux #(.N(N), .W(W)) u_mux_n (
        .sel(north_sel), .flits(slot_flit), .out_valid(north_valid), .out_flit(north_flit)
    );
    hr_out_mux #(.N(N), .W(W)) u_mux_s (
        .sel(south_sel), .flits(slot_flit), .out_valid(south_valid), .out_flit(south_flit)
    );
    hr_out_mux #(.N(N), .W(W)) u_mux_l (
        .sel(local_sel), .flits(slot_flit), .out_valid(local_valid), .out_flit(local_flit)
    );
endmodule

// File: rtl/hinge_turn_select_chk.sv
module hinge_turn_select_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] cfg,
    input logic [N-1:0] in_valid,
    input logic [N-1:0] held,
    input logic [N-1:0] n_sel,
    input logic [N-1:0] s_sel,
    input logic [N-1:0] l_sel,
    input logic [N-1:0] drop,
    input logic         n_valid,
    input logic         s_valid,
    input logic         l_valid
);
    logic [N-1:0] consumed;
    assign consumed = n_sel | s_sel | l_sel | drop;

    p_onehot_north_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(n_sel));
    p_onehot_south_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_sel));
    p_onehot_local_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l_sel));
    p_drop_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop & (n_sel | s_sel | l_sel)) == '0);
    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (held == '0) |-> (drop == '0 && !n_valid && !s_valid && !l_valid));
    p_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((held & $past(consumed & ~in_valid)) == '0));
    p_unexamined_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((held & $past(held & ~cfg & ~in_valid)) == $past(held & ~cfg & ~in_valid)));
    p_load_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((held & $past(in_valid)) == $past(in_valid)));
endmodule

bind hinge_turn_select hinge_turn_select_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg_latch_src),
    .in_valid (in_valid),
    .held     (slot_held),
    .n_sel    (north_sel),
    .s_sel    (south_sel),
    .l_sel    (local_sel),
    .drop     (drop),
    .n_valid  (north_valid),
    .s_valid  (south_valid),
    .l_valid  (local_valid)
);

// File: tb/sim_hinge_turn_select.sv
module sim_hinge_turn_select;
    localparam int N  = 3;
    localparam int W  = 64;
    localparam int XW = 2;
    localparam int YW = 2;

    typedef struct {
        logic          nv;
        logic [W-1:0]  nd;
        logic          sv;
        logic [W-1:0]  sd;
        logic          lv;
        logic [W-1:0]  ld;
        logic [N-1:0]  dr;
        string         tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [XW-1:0]  my_x = 2'd1;
    logic [YW-1:0]  my_y = 2'd1;
    logic [N-1:0]   cfg_latch_src = '0;
    logic [N-1:0]   in_valid = '0;
    logic [N*W-1:0] in_flit = '0;
    logic           north_valid, south_valid, local_valid;
    logic [W-1:0]   north_flit, south_flit, local_flit;
    logic [N-1:0]   north_sel, south_sel, local_sel, drop;

    int n_tests = 0;
    int n_fail  = 0;
    exp_t q[$];
    logic [W-1:0] Z = '0;

    always #10 clk = ~clk;

    hinge_turn_select #(.N(N), .W(W), .XW(XW), .YW(YW)) u0 (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
        .cfg_latch_src(cfg_latch_src), .in_valid(in_valid), .in_flit(in_flit),
        .north_valid(north_valid), .north_flit(north_flit),
        .south_valid(south_valid), .south_flit(south_flit),
        .local_valid(local_valid), .local_flit(local_flit),
        .north_sel(north_sel), .south_sel(south_sel), .local_sel(local_sel),
        .drop(drop)
    );

    function automatic logic [W-1:0] mkf(input logic [1:0] dx, input logic [1:0] dy,
                                         input logic [59:0] p);
        return {p, dy, dx};
    endfunction

    function automatic exp_t mke(input logic nv, input logic [W-1:0] nd,
                                 input logic sv, input logic [W-1:0] sd,
                                 input logic lv, input logic [W-1:0] ld,
                                 input logic [N-1:0] dr, input string tag);
        exp_t e;
        e.nv = nv; e.nd = nd; e.sv = sv; e.sd = sd;
        e.lv = lv; e.ld = ld; e.dr = dr; e.tag = tag;
        return e;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and queue what the outputs must show in it
    task automatic step(input logic [N-1:0] cfg, input logic [N-1:0] av,
                        input logic [W-1:0] f0, input logic [W-1:0] f1,
                        input logic [W-1:0] f2, input exp_t e);
        @(negedge clk);
        cfg_latch_src = cfg;
        in_valid      = av;
        in_flit       = {f2, f1, f0};
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "north_valid", {63'd0, north_valid}, {63'd0, e.nv});
                if (e.nv) check(e.tag, "north_flit", north_flit, e.nd);
                check(e.tag, "south_valid", {63'd0, south_valid}, {63'd0, e.sv});
                if (e.sv) check(e.tag, "south_flit", south_flit, e.sd);
                check(e.tag, "local_valid", {63'd0, local_valid}, {63'd0, e.lv});
                if (e.lv) check(e.tag, "local_flit", local_flit, e.ld);
                check(e.tag, "drop", {61'd0, drop}, {61'd0, e.dr});
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] fa, fb, fc, fd, fe, ff, fg, fh, fi;
        fa = mkf(2'd1, 2'd3, 60'hA5A5_0000_1111_222);
        fb = mkf(2'd1, 2'd0, 60'hBBBB_CCCC_DDDD_EEE);
        fc = mkf(2'd1, 2'd1, 60'hFFFF_0000_FFFF_000);
        fd = mkf(2'd2, 2'd1, 60'h1234_5678_9ABC_DEF);
        fe = mkf(2'd1, 2'd2, 60'h0F0F_0F0F_0F0F_0F0);
        ff = mkf(2'd1, 2'd3, 60'h7777_8888_9999_AAA);
        fg = mkf(2'd1, 2'd0, 60'hC3C3_3C3C_C3C3_3C3);
        fh = mkf(2'd3, 2'd3, 60'hDEAD_BEEF_0000_111);
        fi = mkf(2'd1, 2'd1, 60'h5555_AAAA_5555_AAA);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        step(3'b000, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R1 reset"));
        step(3'b111, 3'b001, fa, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R1 empty"));
        // R2 R5 R10: captured, turned north with all bits intact
        step(3'b111, 3'b000, Z, Z, Z, mke(1,fa,0,Z,0,Z,3'b000,"R5 north R10 R2"));
        // R8: cleared, no repeat
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R8 clear"));
        // R6 R7: two slots at once to different outputs
        step(3'b111, 3'b110, Z, fb, fc, mke(0,Z,0,Z,0,Z,3'b000,"R2 load"));
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,1,fb,1,fc,3'b000,"R6 south R7 local"));
        // R4: foreign column dropped
        step(3'b111, 3'b001, fd, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R4 load"));
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b001,"R4 drop"));
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R4 cleared"));
        // R3: unexamined slot holds its flit
        step(3'b000, 3'b010, Z, fe, Z, mke(0,Z,0,Z,0,Z,3'b000,"R3 load"));
        step(3'b000, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R3 ignored"));
        step(3'b101, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R3 other slots"));
        step(3'b010, 3'b000, Z, Z, Z, mke(1,fe,0,Z,0,Z,3'b000,"R3 released"));
        step(3'b010, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R8 after R3"));
        // R9: arrival during forward wins over clear
        step(3'b111, 3'b100, Z, Z, ff, mke(0,Z,0,Z,0,Z,3'b000,"R9 load"));
        step(3'b111, 3'b100, Z, Z, fg, mke(1,ff,0,Z,0,Z,3'b000,"R9 forward+arrive"));
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,1,fg,0,Z,3'b000,"R9 new held"));
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R9 cleared"));
        // R9 with drop: arrival during drop wins over clear
        step(3'b111, 3'b001, fh, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R9 load drop"));
        step(3'b111, 3'b001, fi, Z, Z, mke(0,Z,0,Z,0,Z,3'b001,"R4 R9 drop+arrive"));
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,0,Z,1,fi,3'b000,"R9 R7 local"));
        step(3'b111, 3'b000, Z, Z, Z, mke(0,Z,0,Z,0,Z,3'b000,"R8 final"));

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule